// File: doc/BRIEF.md
# Eight-Pin General-Purpose I/O Port with Peripheral Direction Override

This block controls a byte-wide group of pads through four byte registers on a small synchronous bus. Software writes an output latch, a per-pin direction mask and a per-pin reduced-drive mask. It reads back the pad levels through a two-stage input synchronizer. The block drives per-pin output-enable, output-value and reduced-drive lines towards the pad ring.

Two kinds of serial peripheral can take over pin direction. An SPI controller claims the pins in a parameter mask whenever it is enabled, and it supplies the direction of each of those pins. An asynchronous serial channel has a transmit pin and a receive pin. An enabled transmitter makes its pin an output, and an enabled receiver makes its pin an input. The stored direction mask is never altered by these overrides, so it takes effect again as soon as the peripheral lets go. The pin register shows the real pad level even on driven pins, which lets software spot a shorted or overloaded output.

Top module: `gpio_port`

## Requirements
- R1: After reset the output latch, the direction mask and the reduced-drive mask are all zero, so `pad_oe`, `pad_out` and `pad_rdrv` are 0.
- R2: With no override active, pin i is an output (`pad_oe[i]`=1) when direction bit i is 1, and an input when it is 0. The direction mask sits at address 1.
- R3: While `ser_tx_en` is 1, pin `TX_PIN` (default 1) is an output whatever its direction bit, unless SPI owns that pin.
- R4: While `ser_rx_en` is 1, pin `RX_PIN` (default 0) is an input whatever its direction bit, unless SPI owns that pin.
- R5: While `spi_en` is 1, each pin in `SPI_PIN_MASK` (default 8'h3C) takes its output-enable from `spi_dir`. SPI ranks above transmit, transmit above receive, and receive above the direction mask.
- R6: When an override is released, the pin follows its stored direction bit again, in the same cycle.
- R7: The reduced-drive mask at address 2 is written by the bus and drives `pad_rdrv` from the clock edge of the write.
- R8: A write to the pin register at address 3 changes no register and no output.
- R9: A pad level change is seen on `bus_rdata` at address 3 on the third rising edge after it: two synchronizer stages plus the read register.
- R10: `pad_out` equals the output latch at address 0. A read of address 0 returns the latch bit for pins whose effective direction is output, and the synchronized pad bit for input pins.
- R11: `bus_rdata` is registered. It reflects the register selected by `bus_addr` at the previous rising edge, and addresses 1 and 2 read back the stored masks.
- R12: The pin register shows the synchronized pad level even on pins driven as outputs, so a pad that disagrees with the latch is visible.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register select: 0 latch, 1 direction, 2 reduced drive, 3 pin |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| spi_en | input | 1 | SPI controller enabled |
| spi_dir | input | 8 | Direction requested by SPI, 1 = output |
| ser_tx_en | input | 1 | Serial transmit channel enabled |
| ser_rx_en | input | 1 | Serial receive channel enabled |
| pad_in | input | 8 | Raw pad input levels |
| pad_oe | output | 8 | Per-pin output enable |
| pad_out | output | 8 | Per-pin output value |
| pad_rdrv | output | 8 | Per-pin reduced-drive select |

## Verification
Output enables depend only on registers and override inputs through logic, so the bench checks them one time unit after it changes an override, and one clock edge after a direction write. Register writes appear on `pad_out` and `pad_rdrv` after the write edge. A read is due one edge after the address is set. A pad change is due on the third edge, and the bench checks it after the second edge, when the old value must still be present, and after the third edge, when the new value must appear. All inputs change on the falling edge, and outputs are sampled on the falling edge or shortly after it.

// File: rtl/gpio_port_pkg.sv
// Shared definitions for the GPIO port: register select codes.
// Assumes a two-bit register address space.
package gpio_port_pkg;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_LATCH = 2'd0,
        SEL_DIR   = 2'd1,
        SEL_RDRV  = 2'd2,
        SEL_PIN   = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/gpio_port_sync.sv
// Multi-stage synchronizer for the pad inputs.
// Assumes each bit is sampled on its own; there is no bus-coherence guarantee.
module gpio_port_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // Purpose: capture the raw pad level.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= '0;
                    else        stage_q[0] <= async_in;
                end
            end else begin : g_next
                // Purpose: pass the value on to settle metastability.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_port_dir_arb.sv
// Per-pin direction arbiter. Priority: SPI over serial transmit, transmit
// over serial receive, receive over the stored direction mask.
// Assumes the parameter pin indices are below WIDTH.
module gpio_port_dir_arb #(
    parameter int               WIDTH        = 8,
    parameter logic [WIDTH-1:0] SPI_PIN_MASK = 8'h3C,
    parameter int               TX_PIN       = 1,
    parameter int               RX_PIN       = 0
) (
    input  logic [WIDTH-1:0] dir_mask,
    input  logic             spi_en,
    input  logic [WIDTH-1:0] spi_dir,
    input  logic             tx_en,
    input  logic             rx_en,
    output logic [WIDTH-1:0] eff_oe
);
    genvar i;
    generate
        for (i = 0; i < WIDTH; i++) begin : g_pin
            localparam bit IS_SPI = SPI_PIN_MASK[i];
            localparam bit IS_TX  = (i == TX_PIN);
            localparam bit IS_RX  = (i == RX_PIN);
            // Purpose: resolve the direction of pin i by priority.
            always_comb begin
                if (IS_SPI && spi_en)     eff_oe[i] = spi_dir[i];
                else if (IS_TX && tx_en)  eff_oe[i] = 1'b1;
                else if (IS_RX && rx_en)  eff_oe[i] = 1'b0;
                else                      eff_oe[i] = dir_mask[i];
            end
        end
    endgenerate
endmodule

// File: rtl/gpio_port_regs.sv
// Register file with registered read port. Address 3 is read-only.
// Assumes one access per cycle, and read data is wanted one edge after the address.
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [WIDTH-1:0]  wdata,
    input  logic [WIDTH-1:0]  eff_oe,
    input  logic [WIDTH-1:0]  pin_sync,
    output logic [WIDTH-1:0]  latch_q,
    output logic [WIDTH-1:0]  dir_q,
    output logic [WIDTH-1:0]  rdrv_q,
    output logic [WIDTH-1:0]  rdata
);
    reg_sel_e              sel;
    logic [WIDTH-1:0]      rd_mux;

    assign sel = reg_sel_e'(addr);

    // Purpose: update the writable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= '0;
            dir_q   <= '0;
            rdrv_q  <= '0;
        end else if (we) begin
            case (sel)
                SEL_LATCH: latch_q <= wdata;
                SEL_DIR:   dir_q   <= wdata;
                SEL_RDRV:  rdrv_q  <= wdata;
                default:   ;
            endcase
        end
    end

    // Purpose: select the read value; the latch view is mixed by direction.
    always_comb begin
        case (sel)
            SEL_LATCH: rd_mux = (latch_q & eff_oe) | (pin_sync & ~eff_oe);
            SEL_DIR:   rd_mux = dir_q;
            SEL_RDRV:  rd_mux = rdrv_q;
            default:   rd_mux = pin_sync;
        endcase
    end

    // Purpose: register read data for a one-cycle read latency.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '0;
        else        rdata <= rd_mux;
    end
endmodule

// File: rtl/gpio_port.sv
// Top of the GPIO port: registers, direction override and input sync.
// Assumes the peripheral enables are synchronous to clk.
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter int               WIDTH        = 8,
    parameter int               SYNC_STAGES  = 2,
    parameter logic [WIDTH-1:0] SPI_PIN_MASK = 8'h3C,
    parameter int               TX_PIN       = 1,
    parameter int               RX_PIN       = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic              spi_en,
    input  logic [WIDTH-1:0]  spi_dir,
    input  logic              ser_tx_en,
    input  logic              ser_rx_en,
    input  logic [WIDTH-1:0]  pad_in,
    output logic [WIDTH-1:0]  pad_oe,
    output logic [WIDTH-1:0]  pad_out,
    output logic [WIDTH-1:0]  pad_rdrv
);
    logic [WIDTH-1:0] pin_sync;
    logic [WIDTH-1:0] dir_q;
    logic [WIDTH-1:0] eff_oe;

    gpio_port_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (pin_sync)
    );

    gpio_port_dir_arb #(
        .WIDTH(WIDTH), .SPI_PIN_MASK(SPI_PIN_MASK),
        .TX_PIN(TX_PIN), .RX_PIN(RX_PIN)
    ) u_arb (
        .dir_mask (dir_q),
        .spi_en   (spi_en),
        .spi_dir  (spi_dir),
        .tx_en    (ser_tx_en),
        .rx_en    (ser_rx_en),
        .eff_oe   (eff_oe)
    );

    gpio_port_regs #(.WIDTH(WIDTH)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (bus_addr),
        .we       (bus_we),
        .wdata    (bus_wdata),
        .eff_oe   (eff_oe),
        .pin_sync (pin_sync),
        .latch_q  (pad_out),
        .dir_q    (dir_q),
        .rdrv_q   (pad_rdrv),
        .rdata    (bus_rdata)
    );

    assign pad_oe = eff_oe;
endmodule

// File: rtl/gpio_port_checker.sv
// Property checker for gpio_port, attached by bind.
// Assumes the same parameters as the checked instance.
module gpio_port_checker
    import gpio_port_pkg::*;
#(
    parameter int               WIDTH        = 8,
    parameter logic [WIDTH-1:0] SPI_PIN_MASK = 8'h3C,
    parameter int               TX_PIN       = 1,
    parameter int               RX_PIN       = 0
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [WIDTH-1:0]  bus_wdata,
    input logic [WIDTH-1:0]  bus_rdata,
    input logic              spi_en,
    input logic [WIDTH-1:0]  spi_dir,
    input logic              ser_tx_en,
    input logic              ser_rx_en,
    input logic [WIDTH-1:0]  pad_in,
    input logic [WIDTH-1:0]  pad_oe,
    input logic [WIDTH-1:0]  pad_out,
    input logic [WIDTH-1:0]  pad_rdrv
);
    logic [2:0] warm_cnt;

    // Purpose: count edges since reset so history-based checks wait.
    always_ff @(posedge clk) begin
        if (!rst_n)             warm_cnt <= '0;
        else if (warm_cnt != 3'd5) warm_cnt <= warm_cnt + 3'd1;
    end

    p_tx_output_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_tx_en && !(spi_en && SPI_PIN_MASK[TX_PIN])) |-> pad_oe[TX_PIN]);

    p_rx_input_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_rx_en && !(spi_en && SPI_PIN_MASK[RX_PIN])) |-> !pad_oe[RX_PIN]);

    p_spi_owns_r5: assert property (@(posedge clk) disable iff (!rst_n)
        spi_en |-> (((pad_oe ^ spi_dir) & SPI_PIN_MASK) == '0));

    p_rdrv_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == SEL_RDRV) |=> (pad_rdrv == $past(bus_wdata)));

    p_pin_readonly_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == SEL_PIN) |=> ($stable(pad_out) && $stable(pad_rdrv)));

    p_pin_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_cnt >= 3'd4 && $past(bus_addr) == SEL_PIN) |-> (bus_rdata == $past(pad_in, 3)));

    p_latch_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == SEL_LATCH) |=> (pad_out == $past(bus_wdata)));
endmodule

bind gpio_port gpio_port_checker #(
    .WIDTH(WIDTH), .SPI_PIN_MASK(SPI_PIN_MASK), .TX_PIN(TX_PIN), .RX_PIN(RX_PIN)
) u_gpio_port_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .spi_en    (spi_en),
    .spi_dir   (spi_dir),
    .ser_tx_en (ser_tx_en),
    .ser_rx_en (ser_rx_en),
    .pad_in    (pad_in),
    .pad_oe    (pad_oe),
    .pad_out   (pad_out),
    .pad_rdrv  (pad_rdrv)
);

// File: tb/gpio_port_bench.sv
`timescale 1ns/1ps
module gpio_port_bench;
    import gpio_port_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       spi_en = 1'b0;
    logic [7:0] spi_dir = '0;
    logic       ser_tx_en = 1'b0;
    logic       ser_rx_en = 1'b0;
    logic [7:0] pad_in = '0;
    logic [7:0] pad_oe, pad_out, pad_rdrv;

    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;

    gpio_port u_gpio_port (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_en(spi_en),
        .spi_dir(spi_dir), .ser_tx_en(ser_tx_en), .ser_rx_en(ser_rx_en),
        .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out), .pad_rdrv(pad_rdrv)
    );

    typedef struct packed {
        logic [7:0] dir;
        logic       spi;
        logic [7:0] sdir;
        logic       tx;
        logic       rx;
        logic [7:0] exp_oe;
        logic [3:0] req;
    } vec_t;

    // SPI pins 2..5, transmit pin 1, receive pin 0.
    localparam vec_t VECS [8] = '{
        '{8'hA5, 1'b0, 8'h00, 1'b0, 1'b0, 8'hA5, 4'd2},  // R2 plain mask
        '{8'h5A, 1'b0, 8'h00, 1'b0, 1'b0, 8'h5A, 4'd2},  // R2 inverse mask
        '{8'h00, 1'b0, 8'h00, 1'b1, 1'b0, 8'h02, 4'd3},  // R3 transmit forces output
        '{8'hFF, 1'b0, 8'h00, 1'b0, 1'b1, 8'hFE, 4'd4},  // R4 receive forces input
        '{8'h00, 1'b1, 8'hFF, 1'b0, 1'b0, 8'h3C, 4'd5},  // R5 SPI drives its pins out
        '{8'hFF, 1'b1, 8'h00, 1'b0, 1'b0, 8'hC3, 4'd5},  // R5 SPI makes its pins inputs
        '{8'h0F, 1'b1, 8'h24, 1'b1, 1'b1, 8'h26, 4'd5},  // R5 all overrides at once
        '{8'h0F, 1'b0, 8'h24, 1'b0, 1'b0, 8'h0F, 4'd6}   // R6 release restores mask
    };

    task automatic check(input int req, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL R%0d: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b0;
        @(negedge clk);
        v = bus_rdata;
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        #1;
        check(1, pad_oe, 8'h00);
        check(1, pad_out, 8'h00);
        check(1, pad_rdrv, 8'h00);
        rd(SEL_DIR, v);  check(1, v, 8'h00);

        // Vector walk: R2..R6 direction arbitration
        for (int i = 0; i < 8; i++) begin
            wr(SEL_DIR, VECS[i].dir);
            spi_en = VECS[i].spi; spi_dir = VECS[i].sdir;
            ser_tx_en = VECS[i].tx; ser_rx_en = VECS[i].rx;
            #1;
            check(int'(VECS[i].req), pad_oe, VECS[i].exp_oe);
        end
        spi_en = 1'b0; ser_tx_en = 1'b0; ser_rx_en = 1'b0; spi_dir = '0;

        // R7 reduced drive; R11 registered readback of the mask
        wr(SEL_RDRV, 8'h9C);
        check(7, pad_rdrv, 8'h9C);
        rd(SEL_RDRV, v);  check(11, v, 8'h9C);

        // R10 latch drives pad_out; read mixes by direction
        wr(SEL_DIR, 8'hF0);
        wr(SEL_LATCH, 8'h3A);
        check(10, pad_out, 8'h3A);
        pad_in = 8'hC6;
        repeat (4) @(negedge clk);
        rd(SEL_LATCH, v);  check(10, v, 8'h36);

        // R8 pin register write is ignored
        wr(SEL_PIN, 8'hFF);
        check(8, pad_out, 8'h3A);
        check(8, pad_rdrv, 8'h9C);
        rd(SEL_DIR, v);  check(8, v, 8'hF0);
        rd(SEL_PIN, v);  check(8, v, 8'hC6);

        // R9 latency: new level due on the third rising edge
        @(negedge clk);
        bus_addr = SEL_PIN;
        pad_in = 8'h5B;
        @(negedge clk);  check(9, bus_rdata, 8'hC6);
        @(negedge clk);  check(9, bus_rdata, 8'hC6);
        @(negedge clk);  check(9, bus_rdata, 8'h5B);

        // R12 pad mismatch on driven pins is visible
        wr(SEL_DIR, 8'hFF);
        pad_in = 8'h38;
        repeat (4) @(negedge clk);
        rd(SEL_PIN, v);  check(12, v, 8'h38);
        check(12, pad_out, 8'h3A);

        // R10 with R5: SPI turns pins 2..5 into inputs, read takes pad bits
        pad_in = 8'hC4;
        spi_en = 1'b1; spi_dir = 8'h00;
        repeat (4) @(negedge clk);
        rd(SEL_LATCH, v);  check(10, v, 8'h06);
        spi_en = 1'b0;
        #1;
        check(6, pad_oe, 8'hFF);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule